// File: doc/BRIEF.md
# Multiplexed-Address Nibble DRAM Port with Per-Bit Write Mask

This block is the device side of the random-access port of a 4-bit-wide dynamic memory whose address arrives in two halves over one 8-bit bus. It watches an active-low row strobe and an active-low column strobe, together with a write/mask-enable pin and a transfer/output-enable pin. All pins are sampled on one system clock, and the strobe edges are found from those samples. When the row strobe falls, the block captures the row half of the address and decides what kind of row cycle follows. The kinds are a normal cycle, a masked cycle (in which the data pins load a per-bit write-enable mask) and a transfer cycle (in which the array is left alone).

Each column-strobe fall inside a normal or masked row cycle captures the column half and then either writes the data pins into the addressed word, bit by bit under the mask, or reads the word. A read drives the data pins only while the output-enable pin is low. Page mode works naturally: as long as the row strobe stays low, every new column strobe makes another access on the same row, using the cycle kind and mask chosen at the row fall. The mask register returns to all ones when the row strobe rises.

The row and column are joined into a 16-bit word address. That address is reduced modulo the `DEPTH` parameter to index the internal array, so simulation can use a small array.

The controller is a four-state machine:
- `ST_IDLE`: the row strobe is high.
- `ST_NORM`: a normal row cycle.
- `ST_MASK`: a masked row cycle.
- `ST_XFER`: a transfer row cycle.

It has these transitions:
- IDLE→XFER: the row strobe falls with output-enable low.
- IDLE→MASK: the row strobe falls with output-enable high and write/mask-enable low.
- IDLE→NORM: the row strobe falls with both pins high.
- NORM/MASK/XFER→IDLE: the row strobe rises.

Top module: `vram_dram_port`

## Requirements
- R1: After reset the data pins are not driven (`dq_oe`=0) and the mask is all ones, so the first normal write stores all four bits.
- R2: The row is taken from `addr` at the row-strobe fall and the column from `addr` at the column-strobe fall. The array index is ({row,col}) modulo `DEPTH`, so with the default `DEPTH`=2048 it is row bits 2:0 and column bits 7:0.
- R3: In a normal row cycle, a column-strobe fall with `wme_n`=0 writes `dq_i` into the addressed word.
- R4: A column-strobe fall with `wme_n`=1 reads the addressed word. `dq_o` carries the word, and `dq_oe`=1 only while `toe_n`=0 and the column strobe stays low. Otherwise `dq_oe`=0.
- R5: When `wme_n`=0 and `toe_n`=1 at the row-strobe fall, `dq_i` at that instant is loaded as the mask. During the following writes, bit i of the word takes the new data if mask bit i is 1 and keeps its old value if mask bit i is 0.
- R6: The mask returns to all ones when the row strobe rises, so a following normal cycle writes all four bits.
- R7: When `toe_n`=0 at the row-strobe fall, the cycle is a transfer: no column access reads or writes the array, and `dq_oe` stays 0.
- R8: In page mode, while the row strobe stays low, each new column-strobe fall makes one more access on the same row, using the cycle kind and mask chosen at the row fall.
- R9: A column-strobe fall while the row strobe is high changes no array word.
- R10: `wme_n` at the row-strobe fall does not affect reads: a read inside a masked row cycle returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| wme_n | input | 1 | Write enable at column fall; mask select at row fall (low active) |
| toe_n | input | 1 | Output enable during reads; transfer select at row fall (low active) |
| addr | input | 8 | Multiplexed row/column address |
| dq_i | input | 4 | Data pins, inbound (write data or mask) |
| dq_o | output | 4 | Data pins, outbound read data |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
Four properties are checked on every cycle: no array access happens in the idle or transfer states, `dq_oe` is raised only inside a normal or masked row cycle, the mask is all ones whenever a normal cycle is active, and the mask is all ones right after any row cycle ends. The stored contents themselves can only be shown by the bench's scenarios. These are the bit-level merge under partial masks, the correct row/column combination, the page-mode sequences, and the proof that a transfer cycle or a stray column strobe left the words alone. The bench shows them by reading words back and comparing them with its own reference array.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_MASK = 2'd2,
        ST_XFER = 2'd3
    } row_state_t;
endpackage

// File: rtl/vdp_sampler.sv
module vdp_sampler #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              wme_n,
    input  logic              toe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall,
    output logic              cas_rise,
    output logic              wme_s,
    output logic              toe_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] dq_s
);
    logic ras_s, cas_s, ras_d, cas_d;

    // One sampling stage for every pin, one more for the strobes to find edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_s  <= 1'b1;
            cas_s  <= 1'b1;
            ras_d  <= 1'b1;
            cas_d  <= 1'b1;
            wme_s  <= 1'b1;
            toe_s  <= 1'b1;
            addr_s <= '0;
            dq_s   <= '0;
        end else begin
            ras_s  <= ras_n;
            cas_s  <= cas_n;
            ras_d  <= ras_s;
            cas_d  <= cas_s;
            wme_s  <= wme_n;
            toe_s  <= toe_n;
            addr_s <= addr;
            dq_s   <= dq_i;
        end
    end

    assign ras_fall = ras_d & ~ras_s;
    assign ras_rise = ~ras_d & ras_s;
    assign cas_fall = cas_d & ~cas_s;
    assign cas_rise = ~cas_d & cas_s;
endmodule

// File: rtl/vdp_row_ctrl.sv
module vdp_row_ctrl
    import vdp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              wme_s,
    input  logic              toe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] dq_s,
    output row_state_t        state,
    output logic [DATA_W-1:0] mask_q,
    output logic [2*ADDR_W-1:0] word_addr,
    output logic              acc_we,
    output logic              acc_re,
    output logic              rd_active
);
    row_state_t        state_d;
    logic [ADDR_W-1:0] row_q;
    logic              in_row;

    // Next-state decision.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!toe_s)      state_d = ST_XFER;
                    else if (!wme_s) state_d = ST_MASK;
                    else             state_d = ST_NORM;
                end
            end
            ST_NORM, ST_MASK, ST_XFER: begin
                if (ras_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Registered outputs: row, mask and read-drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            mask_q    <= '1;
            rd_active <= 1'b0;
        end else begin
            if (state == ST_IDLE && ras_fall) begin
                row_q <= addr_s;
                if (toe_s && !wme_s) mask_q <= dq_s;
            end else if (state != ST_IDLE && ras_rise) begin
                mask_q <= '1;
            end
            if (ras_rise || cas_rise) rd_active <= 1'b0;
            else if (acc_re)          rd_active <= 1'b1;
        end
    end

    // Combinational access strobes toward the array.
    always_comb begin
        in_row    = (state == ST_NORM) || (state == ST_MASK);
        acc_we    = in_row && cas_fall && !wme_s;
        acc_re    = in_row && cas_fall && wme_s;
        word_addr = {row_q, addr_s};
    end
endmodule

// File: rtl/vdp_array.sv
module vdp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 2048
) (
    input  logic                clk,
    input  logic                we,
    input  logic                re,
    input  logic [2*ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   wmask,
    output logic [DATA_W-1:0]   rdata
);
    localparam int SPAN_W = 2 * ADDR_W;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SPAN_W-1:0] folded;
    logic [IDX_W-1:0]  idx;

    assign folded = word_addr % SPAN_W'(DEPTH);
    assign idx    = folded[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= (mem[idx] & ~wmask) | (wdata & wmask);
        if (re) rdata    <= mem[idx];
    end
endmodule

// File: rtl/vram_dram_port.sv
module vram_dram_port
    import vdp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              wme_n,
    input  logic              toe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);
    logic                ras_fall, ras_rise, cas_fall, cas_rise;
    logic                wme_s, toe_s;
    logic [ADDR_W-1:0]   addr_s;
    logic [DATA_W-1:0]   dq_s;
    row_state_t          state;
    logic [DATA_W-1:0]   mask_q;
    logic [2*ADDR_W-1:0] word_addr;
    logic                mem_we, mem_re, rd_active;

    vdp_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .wme_n(wme_n), .toe_n(toe_n), .addr(addr), .dq_i(dq_i),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise),
        .wme_s(wme_s), .toe_s(toe_s), .addr_s(addr_s), .dq_s(dq_s)
    );

    vdp_row_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise),
        .wme_s(wme_s), .toe_s(toe_s), .addr_s(addr_s), .dq_s(dq_s),
        .state(state), .mask_q(mask_q), .word_addr(word_addr),
        .acc_we(mem_we), .acc_re(mem_re), .rd_active(rd_active)
    );

    vdp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .re(mem_re), .word_addr(word_addr),
        .wdata(dq_s), .wmask(mask_q), .rdata(dq_o)
    );

    assign dq_oe = rd_active & ~toe_s;
endmodule

// File: rtl/vdp_checker.sv
module vdp_checker
    import vdp_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input row_state_t        state,
    input logic [DATA_W-1:0] mask,
    input logic              mem_we,
    input logic              mem_re,
    input logic              dq_oe
);
    // R7: a transfer row cycle never touches the array
    a_r7_xfer_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> !(mem_we || mem_re));

    // R9: with the row strobe high no access happens
    a_r9_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !(mem_we || mem_re));

    // R4: the data pins are driven only inside a normal or masked row cycle
    a_r4_oe_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (state == ST_NORM || state == ST_MASK));

    // R6: after a row cycle ends the mask is back to all ones
    a_r6_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) != ST_IDLE) |-> (mask == '1));

    // R6: a normal cycle always sees a full mask
    a_r6_norm_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM) |-> (mask == '1));
endmodule

bind vram_dram_port vdp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .mask(mask_q),
    .mem_we(mem_we), .mem_re(mem_re), .dq_oe(dq_oe)
);

// File: tb/sim_vram_dram_port.sv
module sim_vram_dram_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, wme_n = 1'b1, toe_n = 1'b1;
    logic [7:0] addr = '0;
    logic [3:0] dq_i = '0;
    logic [3:0] dq_o;
    logic       dq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] ref_mem [DEPTH];
    logic [7:0] cur_row;
    logic [3:0] cur_mask;
    bit         cur_xfer;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_dram_port u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .wme_n(wme_n), .toe_n(toe_n), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic int widx(input logic [7:0] r, input logic [7:0] c);
        return int'({r, c}) % DEPTH;
    endfunction

    task automatic step();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic begin_row(input logic [7:0] r, input logic w, input logic t, input logic [3:0] d);
        addr = r; wme_n = w; toe_n = t; dq_i = d;
        step();
        ras_n = 1'b0;
        step();
        wme_n = 1'b1; toe_n = 1'b1;
        cur_row  = r;
        cur_xfer = !t;
        cur_mask = (t && !w) ? d : 4'hF;
    endtask

    task automatic end_row();
        ras_n = 1'b1;
        step();
    endtask

    task automatic col_wr(input logic [7:0] c, input logic [3:0] d);
        int i;
        addr = c; dq_i = d; wme_n = 1'b0;
        step();
        cas_n = 1'b0;
        step();
        cas_n = 1'b1; wme_n = 1'b1;
        step();
        if (!cur_xfer) begin
            i = widx(cur_row, c);
            ref_mem[i] = (ref_mem[i] & ~cur_mask) | (d & cur_mask);
        end
    endtask

    task automatic col_rd(input string tag, input logic [7:0] c);
        logic [3:0] exp;
        exp = ref_mem[widx(cur_row, c)];
        addr = c; wme_n = 1'b1;
        step();
        cas_n = 1'b0;
        step();
        chk({tag, " R4 oe low while toe_n high"}, {7'd0, dq_oe}, 8'd0);
        toe_n = 1'b0;
        step();
        chk({tag, " R4 oe during read"}, {7'd0, dq_oe}, 8'd1);
        chk({tag, " R2 read data"}, {4'd0, dq_o}, {4'd0, exp});
        cas_n = 1'b1;
        step();
        chk({tag, " R4 oe released after column rise"}, {7'd0, dq_oe}, 8'd0);
        toe_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R1 dq_oe after reset", {7'd0, dq_oe}, 8'd0);
        begin_row(8'h00, 1'b1, 1'b1, 4'h0);
        col_wr(8'h00, 4'hF);
        col_rd("R1 first write full", 8'h00);
        end_row();
    endtask

    task automatic t_fill();
        for (int r = 0; r < 4; r++) begin
            begin_row(8'(r), 1'b1, 1'b1, 4'h0);
            for (int c = 0; c < 8; c++) col_wr(8'(c), 4'((r * 5 + c * 3 + 1) & 15));
            end_row();
        end
        for (int r = 0; r < 4; r++) begin
            begin_row(8'(r), 1'b1, 1'b1, 4'h0);
            for (int c = 0; c < 8; c++) col_rd("R3 R8 page readback", 8'(c));
            end_row();
        end
    endtask

    task automatic t_alias_rows();
        begin_row(8'h05, 1'b1, 1'b1, 4'h0);
        col_wr(8'hC3, 4'h9);
        end_row();
        begin_row(8'h0D, 1'b1, 1'b1, 4'h0);
        col_wr(8'h3C, 4'h6);
        end_row();
        begin_row(8'h05, 1'b1, 1'b1, 4'h0);
        col_rd("R2 row5 colC3", 8'hC3);
        end_row();
        begin_row(8'h0D, 1'b1, 1'b1, 4'h0);
        col_rd("R2 rowD col3C", 8'h3C);
        end_row();
    endtask

    task automatic t_masked();
        begin_row(8'h01, 1'b0, 1'b1, 4'b1010);
        col_wr(8'h02, 4'h5);
        col_wr(8'h03, 4'hF);
        col_rd("R5 R8 masked col2", 8'h02);
        col_rd("R5 R8 masked col3", 8'h03);
        end_row();
    endtask

    task automatic t_mask_reset();
        begin_row(8'h01, 1'b1, 1'b1, 4'h0);
        col_wr(8'h02, 4'h0);
        col_wr(8'h03, 4'hF);
        col_rd("R6 full write after masked cycle", 8'h02);
        col_rd("R6 full write after masked cycle", 8'h03);
        end_row();
    endtask

    task automatic t_xfer();
        begin_row(8'h02, 1'b1, 1'b0, 4'h0);
        col_wr(8'h04, ~ref_mem[widx(8'h02, 8'h04)]);
        addr = 8'h04; wme_n = 1'b1;
        step();
        cas_n = 1'b0; toe_n = 1'b0;
        step();
        chk("R7 no drive in transfer", {7'd0, dq_oe}, 8'd0);
        cas_n = 1'b1; toe_n = 1'b1;
        step();
        end_row();
        begin_row(8'h02, 1'b1, 1'b1, 4'h0);
        col_rd("R7 word unchanged", 8'h04);
        end_row();
    endtask

    task automatic t_cas_only();
        addr = 8'h05; dq_i = ~ref_mem[widx(8'h03, 8'h05)]; wme_n = 1'b0;
        step();
        cas_n = 1'b0;
        step();
        cas_n = 1'b1; wme_n = 1'b1;
        step();
        begin_row(8'h03, 1'b1, 1'b1, 4'h0);
        col_rd("R9 row3 col5 unchanged", 8'h05);
        end_row();
        begin_row(8'h00, 1'b1, 1'b1, 4'h0);
        col_rd("R9 row0 col5 unchanged", 8'h05);
        end_row();
    endtask

    task automatic t_masked_read();
        begin_row(8'h03, 1'b0, 1'b1, 4'b0000);
        col_rd("R10 read in masked cycle", 8'h01);
        col_wr(8'h01, ~ref_mem[widx(8'h03, 8'h01)]);
        col_rd("R5 zero mask blocks write", 8'h01);
        end_row();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 4'h0;
        cur_row = '0; cur_mask = 4'hF; cur_xfer = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_fill();
        t_alias_rows();
        t_masked();
        t_mask_reset();
        t_xfer();
        t_cas_only();
        t_masked_read();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule